// File: doc/BRIEF.md
# Maskable interrupt descriptor generator

The block gathers the interrupt sources of a processor core and turns them into the four 32-bit words a kernel handler reads when it is entered: the interrupt descriptor with a two-digit summary field, an external-source descriptor, an instruction cause descriptor and a cause extension descriptor. Seven condition request lines (task timer, alarm timer, real-time I/O done, normal I/O done, overtemperature, interprocessor communicate, maintenance processor) are latched as pending conditions. Each is qualified by a mask register bit, and the three external sources share one mask bit. An instruction cause strobe records an instruction interrupt that no mask can suppress.

A request flag is raised right after an instruction interrupt strobe. A masked-in condition only raises it at the end of the current instruction. When the flag rises, all four words are captured and held unchanged until the interrupt procedure reports, through a taken pulse, that it has run. That pulse drops the flag and clears the instruction interrupt and every pending condition whose mask bit is set at that moment. Unmasked conditions stay pending for later.

Top module: `intr_desc_gen`

## Requirements
- R1: After reset, irq is 0 and all four descriptor words are 32'h0.
- R2: intr_desc is {20'hC1000, X, Y, 4'h0}. Digit X is intr_desc[11:8]: bit 3 is 0, bit 2 is the instruction interrupt, bit 1 is the external interrupt (any of the three external sources) and bit 0 is the task timer. Digit Y is intr_desc[7:4]: bit 3 is 0, bit 2 is real-time I/O done, bit 1 is alarm timer and bit 0 is normal I/O done.
- R3: Each condition bit in X and Y is its pending condition ANDed with its mask bit. The mask bits are cond_mask[0] normal I/O, [1] alarm, [2] real-time I/O, [3] task timer and [4] external. The instruction bit is never masked.
- R4: cond_req bits are [0] normal I/O, [1] alarm, [2] real-time I/O, [3] task timer, [4] overtemperature, [5] interprocessor and [6] maintenance processor. A one-cycle pulse leaves the condition pending until it is serviced. A condition that was pending while masked is reported once its mask bit is set.
- R5: In ext_desc, bit 2 is the maintenance processor, bit 1 is interprocessor communicate and bit 0 is overtemperature, each ANDed with cond_mask[4]. Bits 31:3 are 0.
- R6: An interprocessor pulse is latched only in a cycle where cond_mask[4] is 1. A pulse seen while that bit is 0 is not remembered.
- R7: When the instruction bit is set, cause_desc is {20'hC1000, code, 4'h0}, where code is the icause_code given with the strobe (01 failed lock, 02 failed event, 03 released lock, 04 released event, 05 failed hardware call, 06 kernel request, 07 failed branch reinstate; any other value is reserved and is passed through). Otherwise cause_desc is 0.
- R8: For code 06, xcause_desc is {20'hC1000, kreq_code, 4'h0}. For codes 01 to 04 it is {8'hC7, lock_ptr}. For any other code, or with no instruction interrupt, it is 0. Both values are captured with the strobe.
- R9: If irq is 0, an icause_vld strobe sets irq on the next cycle. A masked-in condition sets irq on the cycle after an instr_end pulse. Without either, irq stays 0.
- R10: While irq is 1 and proc_taken is 0, irq and all four words are unchanged. irq falls on the cycle after proc_taken.
- R11: On proc_taken, the instruction interrupt is cleared, and so is each pending condition whose mask bit is then 1. Others stay pending.
- R12: An icause_vld strobe that arrives while an instruction interrupt is already pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_req | input | 7 | Condition request lines (R4 order) |
| cond_mask | input | 5 | Condition mask bits (R3 order) |
| instr_end | input | 1 | End of the current instruction |
| icause_vld | input | 1 | Instruction interrupt strobe |
| icause_code | input | 8 | Instruction interrupt cause code |
| kreq_code | input | 8 | Kernel request code |
| lock_ptr | input | 24 | Linked task entry pointer for lock causes |
| proc_taken | input | 1 | Interrupt procedure has run |
| intr_desc | output | 32 | Interrupt descriptor |
| ext_desc | output | 32 | External interrupt descriptor |
| cause_desc | output | 32 | Instruction cause descriptor |
| xcause_desc | output | 32 | Cause extension descriptor |
| irq | output | 1 | Interrupt procedure request |

## Verification
Single conditions are raised with their mask bit both set and cleared. This separates the AND gating from the sticky pending store, and shows that the flag waits for the instruction end. The interprocessor line is pulsed once under a cleared external mask and once under a set one, which exposes whether the capture is gated or the bit is simply masked at the output. Instruction strobes with kernel request, lock, hardware call and reserved codes check each extension word format, the immediate raise and the refusal of a second strobe. A service run with a partial mask shows that only masked-in conditions are cleared.

// File: rtl/intr_desc_pkg.sv
package intr_desc_pkg;
    localparam int unsigned COND_N = 7;
    localparam int unsigned MASK_N = 5;
    localparam int unsigned CODE_W = 8;
    localparam int unsigned PTR_W  = 24;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned PFX_W  = WORD_W - CODE_W - 4;
    localparam int unsigned LPFX_W = WORD_W - PTR_W;

    localparam logic [PFX_W-1:0]  WORD_PFX = PFX_W'(20'hC1000);
    localparam logic [LPFX_W-1:0] LOCK_PFX = LPFX_W'(8'hC7);

    // condition bit positions
    localparam int unsigned C_NIO  = 0;
    localparam int unsigned C_ALRM = 1;
    localparam int unsigned C_RTIO = 2;
    localparam int unsigned C_TTMR = 3;
    localparam int unsigned C_OTMP = 4;
    localparam int unsigned C_IPC  = 5;
    localparam int unsigned C_MP   = 6;
    localparam int unsigned M_EXT  = 4;

    // cause codes with extension words
    localparam logic [CODE_W-1:0] CAUSE_KREQ  = CODE_W'(8'h06);
    localparam logic [CODE_W-1:0] CAUSE_LOCK0 = CODE_W'(8'h01);
    localparam logic [CODE_W-1:0] CAUSE_LOCK3 = CODE_W'(8'h04);

    // summary field bit positions in the descriptor word
    localparam int unsigned XY_LSB    = 4;
    localparam int unsigned XY_INSTR  = 6;
    localparam logic [7:0]  XY_CONDMK = 8'h37;

    typedef struct packed {
        logic [COND_N-1:0] pend;
        logic              ipend;
        logic [CODE_W-1:0] icause;
        logic [CODE_W-1:0] icode;
        logic [PTR_W-1:0]  iptr;
    } trk_state_t;

    typedef struct packed {
        logic              irq;
        logic [WORD_W-1:0] intr;
        logic [WORD_W-1:0] ext;
        logic [WORD_W-1:0] cause;
        logic [WORD_W-1:0] xcause;
    } snap_state_t;
endpackage

// File: rtl/intr_pend_trk.sv
module intr_pend_trk
    import intr_desc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COND_N-1:0] cond_req,
    input  logic [MASK_N-1:0] cond_mask,
    input  logic              icause_vld,
    input  logic [CODE_W-1:0] icause_code,
    input  logic [CODE_W-1:0] kreq_code,
    input  logic [PTR_W-1:0]  lock_ptr,
    input  logic              svc,
    input  logic              svc_instr,
    output logic [COND_N-1:0] cond_now,
    output logic              instr_now,
    output logic [CODE_W-1:0] cause_now,
    output logic [CODE_W-1:0] code_now,
    output logic [PTR_W-1:0]  ptr_now
);
    trk_state_t        s_d, s_q;
    logic [COND_N-1:0] incoming;
    logic [COND_N-1:0] mask_exp;

    always_comb begin
        incoming         = cond_req;
        incoming[C_IPC]  = cond_req[C_IPC] & cond_mask[M_EXT];
        mask_exp         = {cond_mask[M_EXT], cond_mask[M_EXT], cond_mask};
        cond_now         = s_q.pend | incoming;
        instr_now        = s_q.ipend | icause_vld;
        cause_now        = s_q.ipend ? s_q.icause : icause_code;
        code_now         = s_q.ipend ? s_q.icode  : kreq_code;
        ptr_now          = s_q.ipend ? s_q.iptr   : lock_ptr;

        s_d      = s_q;
        s_d.pend = (s_q.pend & ~(svc ? mask_exp : '0)) | incoming;
        if (s_q.ipend) begin
            if (svc && svc_instr) begin
                s_d.ipend = 1'b0;
            end
        end else if (icause_vld) begin
            s_d.ipend  = 1'b1;
            s_d.icause = icause_code;
            s_d.icode  = kreq_code;
            s_d.iptr   = lock_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/intr_desc_fmt.sv
module intr_desc_fmt
    import intr_desc_pkg::*;
(
    input  logic [COND_N-1:0] cond_now,
    input  logic [MASK_N-1:0] cond_mask,
    input  logic              instr_now,
    input  logic [CODE_W-1:0] cause_now,
    input  logic [CODE_W-1:0] code_now,
    input  logic [PTR_W-1:0]  ptr_now,
    output logic [7:0]        xy,
    output logic [WORD_W-1:0] intr_w,
    output logic [WORD_W-1:0] ext_w,
    output logic [WORD_W-1:0] cause_w,
    output logic [WORD_W-1:0] xcause_w
);
    logic [2:0] ext_bits;
    logic       is_lock;

    always_comb begin
        ext_bits = cond_now[C_MP:C_OTMP] & {3{cond_mask[M_EXT]}};
        xy = {1'b0, instr_now, |ext_bits, cond_now[C_TTMR] & cond_mask[C_TTMR],
              1'b0, cond_now[C_RTIO] & cond_mask[C_RTIO],
              cond_now[C_ALRM] & cond_mask[C_ALRM],
              cond_now[C_NIO] & cond_mask[C_NIO]};
        intr_w  = {WORD_PFX, xy, 4'h0};
        ext_w   = {{(WORD_W-3){1'b0}}, ext_bits};
        cause_w = instr_now ? {WORD_PFX, cause_now, 4'h0} : '0;
        is_lock = (cause_now >= CAUSE_LOCK0) && (cause_now <= CAUSE_LOCK3);
        if (instr_now && cause_now == CAUSE_KREQ)
            xcause_w = {WORD_PFX, code_now, 4'h0};
        else if (instr_now && is_lock)
            xcause_w = {LOCK_PFX, ptr_now};
        else
            xcause_w = '0;
    end
endmodule

// File: rtl/intr_desc_gen.sv
module intr_desc_gen
    import intr_desc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COND_N-1:0] cond_req,
    input  logic [MASK_N-1:0] cond_mask,
    input  logic              instr_end,
    input  logic              icause_vld,
    input  logic [CODE_W-1:0] icause_code,
    input  logic [CODE_W-1:0] kreq_code,
    input  logic [PTR_W-1:0]  lock_ptr,
    input  logic              proc_taken,
    output logic [WORD_W-1:0] intr_desc,
    output logic [WORD_W-1:0] ext_desc,
    output logic [WORD_W-1:0] cause_desc,
    output logic [WORD_W-1:0] xcause_desc,
    output logic              irq
);
    snap_state_t       s_d, s_q;
    logic              svc;
    logic              svc_instr;
    logic              raise;
    logic [COND_N-1:0] cond_now;
    logic              instr_now;
    logic [CODE_W-1:0] cause_now;
    logic [CODE_W-1:0] code_now;
    logic [PTR_W-1:0]  ptr_now;
    logic [7:0]        xy;
    logic [WORD_W-1:0] intr_w, ext_w, cause_w, xcause_w;

    assign svc       = s_q.irq & proc_taken;
    assign svc_instr = s_q.intr[XY_LSB + XY_INSTR];

    intr_pend_trk trk_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_req    (cond_req),
        .cond_mask   (cond_mask),
        .icause_vld  (icause_vld),
        .icause_code (icause_code),
        .kreq_code   (kreq_code),
        .lock_ptr    (lock_ptr),
        .svc         (svc),
        .svc_instr   (svc_instr),
        .cond_now    (cond_now),
        .instr_now   (instr_now),
        .cause_now   (cause_now),
        .code_now    (code_now),
        .ptr_now     (ptr_now)
    );

    intr_desc_fmt fmt_i (
        .cond_now  (cond_now),
        .cond_mask (cond_mask),
        .instr_now (instr_now),
        .cause_now (cause_now),
        .code_now  (code_now),
        .ptr_now   (ptr_now),
        .xy        (xy),
        .intr_w    (intr_w),
        .ext_w     (ext_w),
        .cause_w   (cause_w),
        .xcause_w  (xcause_w)
    );

    always_comb begin
        raise = !s_q.irq && (xy[XY_INSTR] || (instr_end && |(xy & XY_CONDMK)));
        s_d   = s_q;
        if (raise) begin
            s_d.irq    = 1'b1;
            s_d.intr   = intr_w;
            s_d.ext    = ext_w;
            s_d.cause  = cause_w;
            s_d.xcause = xcause_w;
        end else if (svc) begin
            s_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq         = s_q.irq;
    assign intr_desc   = s_q.intr;
    assign ext_desc    = s_q.ext;
    assign cause_desc  = s_q.cause;
    assign xcause_desc = s_q.xcause;
endmodule

// File: rtl/intr_desc_gen_chk.sv
module intr_desc_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_end,
    input logic        icause_vld,
    input logic        proc_taken,
    input logic [31:0] intr_desc,
    input logic [31:0] ext_desc,
    input logic [31:0] cause_desc,
    input logic [31:0] xcause_desc,
    input logic        irq
);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !intr_desc[11] && !intr_desc[7]);

    assert_ext_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_desc[31:3] == 29'h0);

    assert_cause_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_desc != 32'h0) == intr_desc[10]);

    assert_instr_immediate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && icause_vld) |=> irq);

    assert_raise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (intr_desc[10] || $past(instr_end)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !proc_taken) |=> (irq && $stable(intr_desc) && $stable(ext_desc)
                                  && $stable(cause_desc) && $stable(xcause_desc)));

    assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && proc_taken) |=> !irq);
endmodule

bind intr_desc_gen intr_desc_gen_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_end   (instr_end),
    .icause_vld  (icause_vld),
    .proc_taken  (proc_taken),
    .intr_desc   (intr_desc),
    .ext_desc    (ext_desc),
    .cause_desc  (cause_desc),
    .xcause_desc (xcause_desc),
    .irq         (irq)
);

// File: tb/intr_desc_gen_tb_top.sv
module intr_desc_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cond_req = '0;
    logic [4:0]  cond_mask = '0;
    logic        instr_end = 1'b0;
    logic        icause_vld = 1'b0;
    logic [7:0]  icause_code = '0;
    logic [7:0]  kreq_code = '0;
    logic [23:0] lock_ptr = '0;
    logic        proc_taken = 1'b0;
    logic [31:0] intr_desc, ext_desc, cause_desc, xcause_desc;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    intr_desc_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cond_req(cond_req), .cond_mask(cond_mask),
        .instr_end(instr_end), .icause_vld(icause_vld), .icause_code(icause_code),
        .kreq_code(kreq_code), .lock_ptr(lock_ptr), .proc_taken(proc_taken),
        .intr_desc(intr_desc), .ext_desc(ext_desc), .cause_desc(cause_desc),
        .xcause_desc(xcause_desc), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit [6:0]  m_pend;
    bit        m_ipend;
    int        m_cause, m_code, m_ptr;
    bit        m_irq;
    bit [31:0] m_intr, m_ext, m_cause_w, m_xc;

    function automatic bit [31:0] word_of(int field);
        return 32'hC1000000 + 32'(field) * 16;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_ipend = 0; m_cause = 0; m_code = 0; m_ptr = 0;
            m_irq = 0; m_intr = 0; m_ext = 0; m_cause_w = 0; m_xc = 0;
        end else begin
            bit [6:0] seen, now;
            bit       inow, ext_any;
            int       cz, cd, pt, xyv, extv;
            bit       clear_all;
            seen = cond_req;
            if (!cond_mask[4]) seen[5] = 0;
            now = m_pend | seen;
            inow = m_ipend || icause_vld;
            cz = m_ipend ? m_cause : int'(icause_code);
            cd = m_ipend ? m_code : int'(kreq_code);
            pt = m_ipend ? m_ptr : int'(lock_ptr);
            extv = 0;
            if (cond_mask[4]) extv = int'(now[6:4]);
            ext_any = (extv != 0);
            xyv = 0;
            if (now[0] && cond_mask[0]) xyv += 1;
            if (now[1] && cond_mask[1]) xyv += 2;
            if (now[2] && cond_mask[2]) xyv += 4;
            if (now[3] && cond_mask[3]) xyv += 16;
            if (ext_any) xyv += 32;
            clear_all = m_irq && proc_taken;
            if (clear_all) begin
                for (int i = 0; i < 7; i++) begin
                    int mb;
                    mb = (i >= 4) ? 4 : i;
                    if (cond_mask[mb]) m_pend[i] = 0;
                end
                if (m_intr[10]) m_ipend = 0;
            end else if (!m_ipend && icause_vld) begin
                m_ipend = 1; m_cause = icause_code; m_code = kreq_code; m_ptr = lock_ptr;
            end
            if (clear_all && !m_ipend && icause_vld) begin
                m_ipend = 1; m_cause = icause_code; m_code = kreq_code; m_ptr = lock_ptr;
            end
            m_pend = m_pend | seen;
            if (!m_irq && (inow || (instr_end && xyv != 0))) begin
                m_irq = 1;
                m_intr = word_of(xyv + (inow ? 64 : 0));
                m_ext = 32'(extv);
                m_cause_w = inow ? word_of(cz) : 0;
                if (inow && cz == 6) m_xc = word_of(cd);
                else if (inow && cz >= 1 && cz <= 4) m_xc = 32'hC7000000 + 32'(pt);
                else m_xc = 0;
            end else if (clear_all) begin
                m_irq = 0;
            end
        end
        #3;
        chk("R2 intr_desc vs model", intr_desc, m_intr);
        chk("R5 ext_desc vs model", ext_desc, m_ext);
        chk("R7 cause_desc vs model", cause_desc, m_cause_w);
        chk("R8 xcause_desc vs model", xcause_desc, m_xc);
        chk("R9 irq vs model", {31'h0, irq}, {31'h0, m_irq});
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_end();
        instr_end = 1; tick(); instr_end = 0; tick();
    endtask

    task automatic take();
        proc_taken = 1; tick(); proc_taken = 0; tick();
    endtask

    task automatic strobe(input logic [7:0] c, input logic [7:0] k, input logic [23:0] p);
        icause_vld = 1; icause_code = c; kreq_code = k; lock_ptr = p;
        tick();
        icause_vld = 0; icause_code = 0; kreq_code = 0; lock_ptr = 0;
        tick();
    endtask

    initial begin
        tick(3);
        chk("R1 reset irq", {31'h0, irq}, 32'h0);
        chk("R1 reset intr_desc", intr_desc, 32'h0);
        rst_n = 1; tick();
        chk("R1 after reset xcause", xcause_desc, 32'h0);

        // single masked-in condition, raised only at instruction end
        cond_mask = 5'b11111;
        cond_req = 7'b0000001; tick(); cond_req = 0; tick();
        chk("R9 no irq before instr_end", {31'h0, irq}, 32'h0);
        pulse_end();
        chk("R9 irq after instr_end", {31'h0, irq}, 32'h1);
        chk("R2 normal io word", intr_desc, 32'hC1000010);
        take();
        chk("R10 irq drop after taken", {31'h0, irq}, 32'h0);
        pulse_end();
        chk("R11 serviced condition cleared", {31'h0, irq}, 32'h0);

        // masked pending, reported once unmasked
        cond_mask = 5'b00000;
        cond_req = 7'b0000010; tick(); cond_req = 0; tick();
        pulse_end();
        chk("R3 masked condition no irq", {31'h0, irq}, 32'h0);
        cond_mask = 5'b00010; tick();
        pulse_end();
        chk("R4 sticky alarm reported", intr_desc, 32'hC1000020);
        take();

        // interprocessor capture gating
        cond_mask = 5'b00000;
        cond_req = 7'b0100000; tick(); cond_req = 0; tick();
        cond_mask = 5'b10000; tick();
        pulse_end();
        chk("R6 ipc not captured while masked", {31'h0, irq}, 32'h0);
        cond_req = 7'b1100000; tick(); cond_req = 0; tick();
        pulse_end();
        chk("R6 ipc captured word", intr_desc, 32'hC1000200);
        chk("R5 ext descriptor mp and ipc", ext_desc, 32'h6);
        take();

        // kernel request: immediate, unmaskable
        cond_mask = 5'b00000;
        strobe(8'h06, 8'h5A, 24'h0);
        chk("R9 instr immediate irq", {31'h0, irq}, 32'h1);
        chk("R3 instr bit unmasked", intr_desc, 32'hC1000400);
        chk("R7 kernel request cause", cause_desc, 32'hC1000060);
        chk("R8 kernel request extension", xcause_desc, 32'hC10005A0);
        cond_req = 7'b0001000;
        icause_vld = 1; icause_code = 8'h01; lock_ptr = 24'h123456;
        tick();
        cond_req = 0; icause_vld = 0; icause_code = 0; lock_ptr = 0;
        tick();
        chk("R10 held cause", cause_desc, 32'hC1000060);
        chk("R10 held word", intr_desc, 32'hC1000400);
        take();
        tick();
        chk("R12 second strobe ignored", {31'h0, irq}, 32'h0);

        // lock, hardware call, reserved codes
        strobe(8'h01, 8'h00, 24'hABCDEF);
        chk("R8 lock extension", xcause_desc, 32'hC7ABCDEF);
        chk("R7 lock cause", cause_desc, 32'hC1000010);
        take();
        strobe(8'h05, 8'h33, 24'h111111);
        chk("R8 hw call no extension", xcause_desc, 32'h0);
        chk("R7 hw call cause", cause_desc, 32'hC1000050);
        take();
        strobe(8'h09, 8'h33, 24'h111111);
        chk("R7 reserved cause passes", cause_desc, 32'hC1000090);
        chk("R8 reserved no extension", xcause_desc, 32'h0);
        take();

        // partial clearing on service
        cond_mask = 5'b00001;
        cond_req = 7'b0000011; tick(); cond_req = 0; tick();
        pulse_end();
        chk("R3 only normal io shown", intr_desc, 32'hC1000010);
        take();
        cond_mask = 5'b00010; tick();
        pulse_end();
        chk("R11 unmasked alarm kept", intr_desc, 32'hC1000020);
        take();
        cond_mask = 5'b00011; tick();
        pulse_end();
        chk("R11 both cleared", {31'h0, irq}, 32'h0);

        tick(3);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule